// File: doc/BRIEF.md
# Genlock Reference Nibble Serializer

This block sits on the 8-bit composite sample bus of a line-locked video digitizer. It runs on the double-rate sample clock. During each horizontal sync tip it replaces the sample stream with a short reference packet. A downstream encoder or decoder reads that packet to lock its own colour subcarrier. The packet has thirteen 4-bit nibbles on the low half of the bus: a field identifier, then a 24-bit subcarrier frequency word, then a 24-bit subcarrier phase word.

Packet timing comes from a one-cycle strobe raised at the falling edge of the regenerated horizontal sync. The first nibble appears a fixed, parameterised number of clocks after that strobe. All packet contents are captured on the strobe, so the packet stays coherent even when the upstream loop updates its words part-way through. Three controls shape the bus outside and inside the packet: a suppress control keeps pure video on the bus, and a force-zero control together with the lock flag decides whether idle time carries raw samples or zeros.

Top module: `grs_nibble_inserter`

## Requirements
- R1: While rst_ni is low, bus_o is 8'h00.
- R2: With E0 the clock edge at which hsync_fall_i is sampled high, nibble k (k = 0..12) is on bus_o[3:0] during the cycle after edge E0+START_OFS+k (default START_OFS = 57). bus_o[7:4] is zero during those cycles.
- R3: Nibble 0 is the field identifier. Nibbles 1 to 6 carry frequency bits 23:20, 19:16, … 3:0. Nibbles 7 to 12 carry phase bits 23:20 down to 3:0 in the same way.
- R4: Field-identifier bit 3 is 1 when line_inv_i is 0 (burst at 135 degrees) and 0 when line_inv_i is 1 (V-inverted line, burst at 225 degrees).
- R5: With pal_mode_i = 0 (NTSC), field-identifier bits 2:0 are {1'b0, field_cnt_i[1:0]}. field_cnt_i counts from 0 for the first field, so bit 0 is 0 on odd fields.
- R6: With pal_mode_i = 1 (PAL), field-identifier bits 2:0 are field_cnt_i[2:0] (eight-field count).
- R7: freq_i, phase_i, field_cnt_i, line_inv_i and pal_mode_i are sampled only on the strobe edge. Changing them after the strobe has no effect on the packet on the bus.
- R8: Outside packet cycles, when locked_i is 1 or force_zero_i is 0, bus_o equals video_i from the previous cycle.
- R9: When suppress_i is 1, no packet is inserted and bus_o equals video_i from the previous cycle in every cycle.
- R10: When locked_i is 0 and force_zero_i is 1 (and suppress_i is 0), bus_o is 8'h00 outside packet cycles. The packet is still sent.
- R11: A strobe that arrives while a packet is pending or in progress restarts the timing from the new strobe with newly captured contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| video_i | input | 8 | Digitized composite samples |
| hsync_fall_i | input | 1 | One-cycle strobe at the regenerated horizontal sync falling edge |
| field_cnt_i | input | 3 | Field counter, 0 for the first field |
| line_inv_i | input | 1 | 1 on V-inverted PAL lines |
| pal_mode_i | input | 1 | 0 NTSC, 1 PAL |
| freq_i | input | 24 | Subcarrier frequency word |
| phase_i | input | 24 | Subcarrier phase word |
| suppress_i | input | 1 | 1 disables packet insertion |
| force_zero_i | input | 1 | With lock lost, zero the bus outside packets |
| locked_i | input | 1 | Horizontal loop lock flag |
| bus_o | output | 8 | Composite output bus |

## Verification
The output bus is a register, so a video sample shows up one cycle after it is driven. A packet nibble k is due in the cycle after edge START_OFS+k, counted from the edge that samples the strobe. The bench counts edges from the strobe edge. It samples on the falling clock edge and compares each cycle either with the sample it drove one cycle earlier or with the nibble due at that count. Right after every strobe it scrambles the packet inputs, so any late sampling would show up in the comparison. The restart case launches a second strobe in the middle of a packet and checks the whole window against the second strobe only.

// File: rtl/grs_pkg.sv
package grs_pkg;
  localparam int NIB_W   = 4;
  localparam int WORD_W  = 24;
  localparam int VID_W   = 8;
  localparam int NPW     = WORD_W / NIB_W;
  localparam int NIB_CNT = 1 + 2 * NPW;
  localparam int IDX_W   = $clog2(NIB_CNT);

  function automatic logic [NIB_W-1:0] make_fid(input logic pal, input logic [2:0] fcnt,
                                                 input logic inv);
    return {~inv, pal ? fcnt : {1'b0, fcnt[1:0]}};
  endfunction
endpackage

// File: rtl/grs_slot_timer.sv
module grs_slot_timer
  import grs_pkg::*;
#(
  parameter int START_OFS = 57
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  output logic             slot_valid_o,
  output logic [IDX_W-1:0] slot_idx_o
);
  localparam int LAST  = START_OFS + NIB_CNT - 1;
  localparam int POS_W = $clog2(LAST + 2);

  logic             active_q;
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (strobe_i) begin
      active_q <= 1'b1;
      pos_q    <= POS_W'(1);
    end else if (active_q) begin
      if (pos_q == POS_W'(LAST)) begin
        active_q <= 1'b0;
        pos_q    <= '0;
      end else begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  assign slot_valid_o = active_q && (pos_q >= POS_W'(START_OFS));
  assign slot_idx_o   = IDX_W'(pos_q - POS_W'(START_OFS));
endmodule

// File: rtl/grs_packet_reg.sv
module grs_packet_reg
  import grs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              pal_i,
  input  logic [2:0]        field_cnt_i,
  input  logic              line_inv_i,
  input  logic [WORD_W-1:0] freq_i,
  input  logic [WORD_W-1:0] phase_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [NIB_W-1:0]  nib_o,
  output logic [WORD_W-1:0] held_freq_o
);
  logic [NIB_W-1:0]  fid_q;
  logic [WORD_W-1:0] freq_q, phase_q;
  logic [NIB_W-1:0]  nib_arr [NIB_CNT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fid_q   <= '0;
      freq_q  <= '0;
      phase_q <= '0;
    end else if (capture_i) begin
      fid_q   <= make_fid(pal_i, field_cnt_i, line_inv_i);
      freq_q  <= freq_i;
      phase_q <= phase_i;
    end
  end

  assign nib_arr[0] = fid_q;
  for (genvar k = 0; k < NPW; k++) begin : g_nib
    assign nib_arr[1 + k]       = freq_q[WORD_W-1-NIB_W*k -: NIB_W];
    assign nib_arr[1 + NPW + k] = phase_q[WORD_W-1-NIB_W*k -: NIB_W];
  end

  always_comb begin
    nib_o = '0;
    for (int i = 0; i < NIB_CNT; i++)
      if (idx_i == IDX_W'(i)) nib_o = nib_arr[i];
  end

  assign held_freq_o = freq_q;
endmodule

// File: rtl/grs_bus_mux.sv
module grs_bus_mux
  import grs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VID_W-1:0] video_i,
  input  logic             slot_valid_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             suppress_i,
  input  logic             force_zero_i,
  input  logic             locked_i,
  output logic [VID_W-1:0] bus_o
);
  logic [VID_W-1:0] bus_d;

  always_comb begin
    if (suppress_i)                    bus_d = video_i;
    else if (slot_valid_i)             bus_d = {{(VID_W-NIB_W){1'b0}}, nib_i};
    else if (!locked_i && force_zero_i) bus_d = '0;
    else                               bus_d = video_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_o <= '0;
    else         bus_o <= bus_d;
  end
endmodule

// File: rtl/grs_nibble_inserter.sv
module grs_nibble_inserter
  import grs_pkg::*;
#(
  parameter int START_OFS = 57
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VID_W-1:0]  video_i,
  input  logic              hsync_fall_i,
  input  logic [2:0]        field_cnt_i,
  input  logic              line_inv_i,
  input  logic              pal_mode_i,
  input  logic [WORD_W-1:0] freq_i,
  input  logic [WORD_W-1:0] phase_i,
  input  logic              suppress_i,
  input  logic              force_zero_i,
  input  logic              locked_i,
  output logic [VID_W-1:0]  bus_o
);
  logic             slot_valid;
  logic [IDX_W-1:0] slot_idx;
  logic [NIB_W-1:0] nib;
  logic [WORD_W-1:0] held_freq;

  grs_slot_timer #(.START_OFS(START_OFS)) timer_i (
    .clk_i, .rst_ni, .strobe_i(hsync_fall_i),
    .slot_valid_o(slot_valid), .slot_idx_o(slot_idx)
  );

  grs_packet_reg pkt_i (
    .clk_i, .rst_ni, .capture_i(hsync_fall_i), .pal_i(pal_mode_i),
    .field_cnt_i, .line_inv_i, .freq_i, .phase_i,
    .idx_i(slot_idx), .nib_o(nib), .held_freq_o(held_freq)
  );

  grs_bus_mux mux_i (
    .clk_i, .rst_ni, .video_i, .slot_valid_i(slot_valid), .nib_i(nib),
    .suppress_i, .force_zero_i, .locked_i, .bus_o
  );
endmodule

// File: rtl/grs_checker.sv
module grs_checker
  import grs_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [VID_W-1:0]  video_i,
  input logic              hsync_fall_i,
  input logic              suppress_i,
  input logic              force_zero_i,
  input logic              locked_i,
  input logic              slot_valid,
  input logic [WORD_W-1:0] held_freq,
  input logic [VID_W-1:0]  bus_o
);
  // R9
  suppress_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress_i |=> bus_o == $past(video_i));

  // R2
  hi_nibble_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid && !suppress_i) |=> bus_o[7:4] == 4'h0);

  // R10
  zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slot_valid && !suppress_i && force_zero_i && !locked_i) |=> bus_o == '0);

  // R8
  raw_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slot_valid && !suppress_i && (locked_i || !force_zero_i)) |=> bus_o == $past(video_i));

  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_valid && !hsync_fall_i) |=> $stable(held_freq));
endmodule

bind grs_nibble_inserter grs_checker chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .video_i(video_i), .hsync_fall_i(hsync_fall_i),
  .suppress_i(suppress_i), .force_zero_i(force_zero_i), .locked_i(locked_i),
  .slot_valid(slot_valid), .held_freq(held_freq), .bus_o(bus_o)
);

// File: tb/grs_nibble_inserter_tb.sv
module grs_nibble_inserter_tb_top;
  localparam int OFS = 57;
  localparam int NC  = 13;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  video_i = '0;
  logic        hsync_fall_i = 1'b0;
  logic [2:0]  field_cnt_i = '0;
  logic        line_inv_i = 1'b0;
  logic        pal_mode_i = 1'b0;
  logic [23:0] freq_i = '0;
  logic [23:0] phase_i = '0;
  logic        suppress_i = 1'b0;
  logic        force_zero_i = 1'b0;
  logic        locked_i = 1'b1;
  logic [7:0]  bus_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] prev_vid = '0;
  int vseed = 1;

  always #10 clk_i = ~clk_i;

  grs_nibble_inserter #(.START_OFS(OFS)) dut_i (.*);

  // {pal, fcnt[2:0], inv, sup, fz, lk, freq[23:0], phase[23:0]}
  localparam logic [55:0] TBL [7] = '{
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 24'h21F07C, 24'h123456},
    {1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 24'hA5C3E1, 24'h0F1E2D},
    {1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1, 24'h2A098A, 24'hFEDCBA},
    {1'b1, 3'd6, 1'b0, 1'b0, 1'b1, 1'b0, 24'h13579B, 24'h2468AC},
    {1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 24'h876543, 24'h55AA33},
    {1'b0, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 24'h777777, 24'h999999},
    {1'b1, 3'd3, 1'b1, 1'b0, 1'b1, 1'b1, 24'hC0FFEE, 24'h0BADF0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_nib(input logic [55:0] v, input int k);
    logic [3:0] fid;
    fid = {~v[51], v[55] ? v[54:52] : {1'b0, v[53:52]}};
    if (k == 0) return fid;
    if (k <= 6) return v[47 - 4*(k-1) -: 4];
    return v[23 - 4*(k-7) -: 4];
  endfunction

  task automatic drive_video();
    vseed = vseed * 5 + 11;
    video_i  = 8'(vseed) | 8'h90;
    prev_vid = video_i;
  endtask

  task automatic apply(input logic [55:0] v);
    pal_mode_i   = v[55];
    field_cnt_i  = v[54:52];
    line_inv_i   = v[51];
    suppress_i   = v[50];
    force_zero_i = v[49];
    locked_i     = v[48];
    freq_i       = v[47:24];
    phase_i      = v[23:0];
  endtask

  task automatic scramble();
    freq_i      = ~freq_i;
    phase_i     = ~phase_i;
    field_cnt_i = field_cnt_i + 3'd3;
    line_inv_i  = ~line_inv_i;
    pal_mode_i  = ~pal_mode_i;
  endtask

  // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
  task automatic run_packet(input logic [55:0] v, input bit prestart);
    logic [7:0] exp;
    string req;
    if (prestart) begin
      apply(v ^ {8'h0, 48'hFFFFFF_FFFFFF});
      hsync_fall_i = 1'b1;
      @(posedge clk_i); @(negedge clk_i);
      hsync_fall_i = 1'b0;
      for (int i = 0; i < OFS + 3; i++) begin
        drive_video();
        @(posedge clk_i); @(negedge clk_i);
      end
    end
    apply(v);
    hsync_fall_i = 1'b1;
    drive_video();
    @(posedge clk_i); @(negedge clk_i);
    hsync_fall_i = 1'b0;
    scramble();
    drive_video();
    for (int n = 1; n <= OFS + NC + 1; n++) begin
      logic [7:0] pv;
      pv = prev_vid;
      @(posedge clk_i); @(negedge clk_i);
      if (v[50]) begin
        exp = pv; req = "R9";
      end else if (n >= OFS && n < OFS + NC) begin
        exp = {4'h0, exp_nib(v, n - OFS)};
        req = prestart ? "R11" : (n == OFS ? (v[55] ? "R6/R4" : "R5/R4") : "R3/R2/R7");
      end else if (!v[48] && v[49]) begin
        exp = 8'h00; req = "R10";
      end else begin
        exp = pv; req = prestart ? "R11" : "R8";
      end
      check(req, bus_o, exp);
      drive_video();
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    video_i = 8'hFF;
    hsync_fall_i = 1'b1;
    @(negedge clk_i);
    check("R1", bus_o, 8'h00);
    hsync_fall_i = 1'b0;
    @(negedge clk_i);
    check("R1", bus_o, 8'h00);
    rst_ni = 1'b1;
    drive_video();
    repeat (4) @(negedge clk_i);
    for (int i = 0; i < 7; i++) run_packet(TBL[i], 1'b0);
    run_packet({1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 24'h4C5D6E, 24'h7F8091}, 1'b1);
    run_packet({1'b0, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 24'h010203, 24'hF0E0D0}, 1'b1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule